// File: doc/BRIEF.md
# Eight-Element Logic Slice with Hard Lookahead Carry

The block is one column segment of programmable logic: eight elements, each built around a 6-input lookup table that splits into two 5-input halves sharing the low five inputs. In logic mode every element returns its full 6-input table lookup. In arithmetic mode the low half of each table is read as the carry-propagate term and the high half as the carry-generate term. A hardened lookahead unit, spanning exactly the eight elements, forms every internal carry in parallel from those terms and the segment carry-in. Each element then outputs one sum bit, propagate XOR incoming carry.

Because the arithmetic terms come out of user tables, the same slice serves as an adder, a subtractor or any other function that fits the generate/propagate form. The arithmetic uses no input pins beyond the table inputs. The carry-in is picked by a configuration field: constant 0, constant 1, or the carry-out of the segment below. A chain therefore always starts on an eight-element boundary. Configuration enters through a one-bit shift port. Element outputs and the carry-out are registered. A combinational copy of the carry-out feeds the next segment on the dedicated carry path.

Top module: `lslice_top`

## Requirements
- R1: After synchronous reset, `y` and `cout` are 0 and the whole configuration image is 0, so every table holds all zeros and the carry-in select is 00.
- R2: Each cycle with `cfg_en` high, the 514-bit configuration image shifts one place toward bit 0, and `cfg_din` enters at bit 513. The bit sent first ends at bit 0. Bits [1:0] are the carry-in select. Bits [2+64e +: 64] are the table of element e, and table bit n is the output for a 6-bit element input of value n.
- R3: With `arith_en` low, `y[e]` one cycle later equals table bit `lut_in[6e+5:6e]` of element e, and `cout` is 0.
- R4: With `arith_en` high, propagate of element e is its table bit at index `lut_in[6e+4:6e]`, and generate is the bit at 32 plus that index. Input bit `lut_in[6e+5]` has no effect on any output.
- R5: In arithmetic mode, c0 is the segment carry-in and c[i+1] = g[i] | (p[i] & c[i]). `y[i]` one cycle later is p[i] XOR c[i], and `cout` is c8.
- R6: Carry-in select 00 gives carry-in 0, 01 gives 1, and 10 or 11 take `cin_prev`.
- R7: While `cfg_en` is high, `y` and `cout` keep their values whatever the other inputs do.
- R8: `cout_chain` equals c8 in the same cycle without a register in arithmetic mode, and it is 0 in logic mode. `cout` one cycle after a cycle with `cfg_en` low equals the `cout_chain` of that cycle.
- R9: With tables where propagate is in[0] XOR in[1] and generate is in[0] AND in[1], the registered `{cout, y}` equals A + B + carry-in, where A and B are the per-element in[0] and in[1] bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | Shift enable for the configuration chain; freezes the output registers |
| cfg_din | input | 1 | Serial configuration data |
| arith_en | input | 1 | 1 = arithmetic mode, 0 = logic mode |
| lut_in | input | 48 | Six table inputs per element; element e uses [6e+5:6e] |
| cin_prev | input | 1 | Carry-out of the segment below |
| y | output | 8 | Registered element outputs (table result or sum) |
| cout | output | 1 | Registered segment carry-out |
| cout_chain | output | 1 | Unregistered carry-out for the next segment |

## Verification
Configuration shifting and output capture can fall on the same clock edge. During every load the bench drives random table inputs, flips the mode and changes `cin_prev` on each shift cycle, and it expects the previous output word to stay in place for every one of those cycles. In the same run, a carry that starts at the segment carry-in can ripple through all eight propagate terms, with A=FF and B=00 under constant carry-in 1, or meet a generate at bit 7. The bench checks these cases against integer addition and against the unregistered carry-out in the cycle it is driven.

// File: rtl/lslice_pkg.sv
// Package: shared sizes and the carry-in source encoding for the logic slice.
// Assumes the configuration image keeps the carry-in select in its two lowest bits.
package lslice_pkg;
    localparam int CSEL_W = 2;

    typedef enum logic [CSEL_W-1:0] {
        CIN_ZERO     = 2'b00,
        CIN_ONE      = 2'b01,
        CIN_PREV     = 2'b10,
        CIN_PREV_ALT = 2'b11
    } cin_src_e;
endpackage

// File: rtl/lslice_cfg_chain.sv
// Configuration shift register for the slice. Bit 0 is the oldest bit. The
// carry-in select sits at the bottom, and the element tables follow in order.
// Assumes cfg_en is held for exactly CHAIN_W cycles per full load.
module lslice_cfg_chain
    import lslice_pkg::*;
#(
    parameter int N_ELEM = 8,
    parameter int MASK_W = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_en,
    input  logic                       cfg_din,
    output logic [N_ELEM*MASK_W-1:0]   masks,
    output cin_src_e                   cin_src
);
    localparam int CHAIN_W = N_ELEM * MASK_W + CSEL_W;

    logic [CHAIN_W-1:0] chain_q;

    // Shift one bit toward bit 0 per enabled cycle; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else if (cfg_en) begin
            chain_q <= {cfg_din, chain_q[CHAIN_W-1:1]};
        end
    end

    assign masks   = chain_q[CHAIN_W-1:CSEL_W];
    assign cin_src = cin_src_e'(chain_q[CSEL_W-1:0]);

    // R2: the serial bit lands at the top of the chain.
    a_r2_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> chain_q[CHAIN_W-1] == $past(cfg_din));

    // R2: no enable, no movement.
    a_r2_chain_still: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> $stable(chain_q));
endmodule

// File: rtl/lslice_lut_elem.sv
// Fracturable K-input lookup table: two (K-1)-input halves share the low
// inputs, and the top input selects between them for the full function.
// The low half is the propagate term and the high half is the generate term.
// Assumes table bit n answers input value n.
module lslice_lut_elem #(
    parameter int K = 6
) (
    input  logic [K-1:0]      sel,
    input  logic [2**K-1:0]   mask,
    output logic              full_o,
    output logic              prop_o,
    output logic              gen_o
);
    localparam int HALF = 2 ** (K - 1);

    logic [HALF-1:0] lo_half;
    logic [HALF-1:0] hi_half;
    logic            lo_out;
    logic            hi_out;

    assign lo_half = mask[HALF-1:0];
    assign hi_half = mask[2*HALF-1:HALF];

    // Look up both halves from the shared low inputs.
    always_comb begin
        lo_out = lo_half[sel[K-2:0]];
        hi_out = hi_half[sel[K-2:0]];
    end

    assign full_o = sel[K-1] ? hi_out : lo_out;
    assign prop_o = lo_out;
    assign gen_o  = hi_out;
endmodule

// File: rtl/lslice_cla.sv
// Hard lookahead carry unit for one segment. Every carry is formed directly
// from the generate/propagate terms and the carry-in, with no bit waiting on
// the carry below it. Assumes c[0] is the segment carry-in.
module lslice_cla #(
    parameter int W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  p,
    input  logic [W-1:0]  g,
    input  logic          cin,
    output logic [W:0]    c
);
    // Flat sum-of-products carries: c[i] = OR over j of g[j]*p[j+1..i-1], plus p[0..i-1]*cin.
    always_comb begin
        logic acc;
        logic run;
        c[0] = cin;
        for (int i = 1; i <= W; i++) begin
            acc = 1'b0;
            run = 1'b1;
            for (int j = i - 1; j >= 0; j--) begin
                acc = acc | (run & g[j]);
                run = run & p[j];
            end
            c[i] = acc | (run & cin);
        end
    end

    // R5: the parallel form agrees with the bit-serial recurrence at every bit.
    for (genvar i = 0; i < W; i++) begin : g_chk
        a_r5_carry_recur: assert property (@(posedge clk) disable iff (!rst_n)
            c[i+1] == (g[i] | (p[i] & c[i])));
    end
endmodule

// File: rtl/lslice_top.sv
// Eight-element logic slice. Each element is a fracturable table. In
// arithmetic mode the hard lookahead unit carries across the segment, and each
// element gives one sum bit. Outputs are registered and hold while
// configuration shifts. Assumes cin_prev comes from the cout_chain of the
// segment below.
module lslice_top
    import lslice_pkg::*;
#(
    parameter int N_ELEM = 8,
    parameter int K      = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_en,
    input  logic                 cfg_din,
    input  logic                 arith_en,
    input  logic [N_ELEM*K-1:0]  lut_in,
    input  logic                 cin_prev,
    output logic [N_ELEM-1:0]    y,
    output logic                 cout,
    output logic                 cout_chain
);
    localparam int MASK_W = 2 ** K;

    logic [N_ELEM*MASK_W-1:0] masks_w;
    cin_src_e                 cin_src_w;
    logic [N_ELEM-1:0]        full_w;
    logic [N_ELEM-1:0]        prop_w;
    logic [N_ELEM-1:0]        gen_w;
    logic [N_ELEM:0]          carry_w;
    logic                     seg_cin;
    logic [N_ELEM-1:0]        sum_w;

    lslice_cfg_chain #(
        .N_ELEM (N_ELEM),
        .MASK_W (MASK_W)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_en  (cfg_en),
        .cfg_din (cfg_din),
        .masks   (masks_w),
        .cin_src (cin_src_w)
    );

    for (genvar e = 0; e < N_ELEM; e++) begin : g_elem
        lslice_lut_elem #(.K(K)) u_lut (
            .sel    (lut_in[e*K +: K]),
            .mask   (masks_w[e*MASK_W +: MASK_W]),
            .full_o (full_w[e]),
            .prop_o (prop_w[e]),
            .gen_o  (gen_w[e])
        );
    end

    // Pick the segment carry-in from the configured source.
    always_comb begin
        unique case (cin_src_w)
            CIN_ZERO:     seg_cin = 1'b0;
            CIN_ONE:      seg_cin = 1'b1;
            CIN_PREV,
            CIN_PREV_ALT: seg_cin = cin_prev;
            default:      seg_cin = 1'b0;
        endcase
    end

    lslice_cla #(.W(N_ELEM)) u_cla (
        .clk   (clk),
        .rst_n (rst_n),
        .p     (prop_w),
        .g     (gen_w),
        .cin   (seg_cin),
        .c     (carry_w)
    );

    assign sum_w      = prop_w ^ carry_w[N_ELEM-1:0];
    assign cout_chain = arith_en & carry_w[N_ELEM];

    // Capture the element outputs and carry-out unless configuration is shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y    <= '0;
            cout <= 1'b0;
        end else if (!cfg_en) begin
            y    <= arith_en ? sum_w : full_w;
            cout <= arith_en & carry_w[N_ELEM];
        end
    end

    // R7: output registers frozen during a shift cycle.
    a_r7_hold_out: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> ($stable(y) && $stable(cout)));

    // R3: logic mode captures the full table results.
    a_r3_logic_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_en && !arith_en) |=> (y == $past(full_w) && !cout));

    // R5: arithmetic mode captures propagate XOR carry from the lookahead unit.
    a_r5_sum_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_en && arith_en) |=> y == $past(prop_w ^ carry_w[N_ELEM-1:0]));

    // R8: registered carry-out follows the chain carry of the previous cycle.
    a_r8_chain_reg: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> cout == $past(cout_chain));
endmodule

// File: tb/lslice_top_tb.sv
// Scoreboard bench: the driver tasks queue the expected output word, and the
// monitor compares it after the capturing edge.
module lslice_top_tb;
    localparam int NE = 8;
    localparam int CW = NE * 64 + 2;

    typedef struct {
        logic [7:0] y;
        logic       co;
        string      tag;
    } sb_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en = 1'b0;
    logic        cfg_din = 1'b0;
    logic        arith_en = 1'b0;
    logic [47:0] lut_in = '0;
    logic        cin_prev = 1'b0;
    logic [7:0]  y;
    logic        cout;
    logic        cout_chain;

    sb_item_t    sb_q[$];
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 1'b0;
    logic [63:0] mask_m [NE];
    logic [1:0]  csel_m = 2'b00;
    logic [8:0]  last_exp = '0;

    always #5 clk = ~clk;

    lslice_top u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_en     (cfg_en),
        .cfg_din    (cfg_din),
        .arith_en   (arith_en),
        .lut_in     (lut_in),
        .cin_prev   (cin_prev),
        .y          (y),
        .cout       (cout),
        .cout_chain (cout_chain)
    );

    function automatic logic [47:0] rnd48();
        logic [63:0] r;
        r = {$urandom(), $urandom()};
        return r[47:0];
    endfunction

    // Independent model of the slice, with a bit-serial carry.
    function automatic logic [8:0] model(input logic [47:0] ins, input logic ar, input logic cp);
        logic       c;
        logic       p;
        logic       g;
        logic [7:0] yv;
        logic [5:0] s;
        c = (csel_m == 2'b00) ? 1'b0 : (csel_m == 2'b01) ? 1'b1 : cp;
        for (int e = 0; e < NE; e++) begin
            s = ins[e*6 +: 6];
            if (!ar) begin
                yv[e] = mask_m[e][s];
            end else begin
                p = mask_m[e][{1'b0, s[4:0]}];
                g = mask_m[e][{1'b1, s[4:0]}];
                yv[e] = p ^ c;
                c = g | (p & c);
            end
        end
        return {ar & c, yv};
    endfunction

    task automatic check1(input logic act, input logic exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // Monitor: pops one expected word after each capturing edge.
    always @(posedge clk) begin
        #2;
        if (sb_q.size() > 0) begin
            sb_item_t it;
            it = sb_q.pop_front();
            n_cmp++;
            if (y !== it.y || cout !== it.co) begin
                n_bad++;
                $display("FAIL %s: actual y=%h cout=%b expected y=%h cout=%b",
                         it.tag, y, cout, it.y, it.co);
            end
        end
    end

    task automatic drive(input logic [47:0] ins, input logic ar, input logic cp,
                         input logic [8:0] exp, input string tag);
        @(negedge clk);
        cfg_en   = 1'b0;
        lut_in   = ins;
        arith_en = ar;
        cin_prev = cp;
        sb_q.push_back('{exp[7:0], exp[8], tag});
        last_exp = exp;
    endtask

    // R7: shift in mask_m/csel_m while scrambling the other inputs; outputs must hold.
    task automatic load_cfg();
        logic [CW-1:0] img;
        img[1:0] = csel_m;
        for (int e = 0; e < NE; e++) img[2 + 64*e +: 64] = mask_m[e];
        for (int k = 0; k < CW; k++) begin
            @(negedge clk);
            cfg_en   = 1'b1;
            cfg_din  = img[k];
            lut_in   = rnd48();
            arith_en = 1'($urandom());
            cin_prev = 1'($urandom());
            sb_q.push_back('{last_exp[7:0], last_exp[8], "R7"});
        end
    endtask

    // Adder operands A,B on in[0],in[1]; bits 2..5 random (R4 says they are ignored).
    task automatic add_vec(input logic [7:0] a, input logic [7:0] b, input logic cp, input string tag);
        logic [47:0] ins;
        logic [8:0]  exp;
        logic        cv;
        ins = rnd48();
        for (int e = 0; e < NE; e++) begin
            ins[e*6]     = a[e];
            ins[e*6 + 1] = b[e];
        end
        cv  = (csel_m == 2'b00) ? 1'b0 : (csel_m == 2'b01) ? 1'b1 : cp;
        exp = 9'(a) + 9'(b) + 9'(cv);
        drive(ins, 1'b1, cp, exp, tag);
        #1 check1(cout_chain, exp[8], "R8 chain carry");
    endtask

    task automatic set_adder_masks(input logic [1:0] cs);
        for (int e = 0; e < NE; e++) begin
            for (int i = 0; i < 32; i++) begin
                mask_m[e][i]      = i[0] ^ i[1];
                mask_m[e][32 + i] = i[0] & i[1];
            end
        end
        csel_m = cs;
    endtask

    initial begin
        for (int e = 0; e < NE; e++) mask_m[e] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check1(y == 8'h00, 1'b1, "R1 y after reset");
        check1(cout, 1'b0, "R1 cout after reset");
        // R1: cleared tables give 0 in logic mode for any input.
        for (int i = 0; i < 4; i++) drive(rnd48(), 1'b0, 1'b0, 9'h000, "R1");
        drive(rnd48(), 1'b1, 1'b1, 9'h000, "R1 cleared tables sum");

        // R2: one set bit in element 3 at index 41 checks the layout.
        mask_m[3] = 64'd1 << 41;
        csel_m = 2'b00;
        load_cfg();
        drive(48'(41) << 18, 1'b0, 1'b0, 9'h008, "R2");
        drive(48'(40) << 18, 1'b0, 1'b0, 9'h000, "R2");
        mask_m[3] = '0;

        // R9/R5 with constant carry-in 0.
        set_adder_masks(2'b00);
        load_cfg();
        add_vec(8'hFF, 8'h01, 1'b1, "R9 full ripple");
        add_vec(8'hFF, 8'hFF, 1'b0, "R9 all generate");
        add_vec(8'h00, 8'h00, 1'b1, "R6 zero ignores prev");
        for (int i = 0; i < 30; i++) add_vec(8'($urandom()), 8'($urandom()), 1'($urandom()), "R9");

        // R6: constant carry-in 1.
        set_adder_masks(2'b01);
        load_cfg();
        add_vec(8'hFF, 8'h00, 1'b0, "R6 one ripples through");
        for (int i = 0; i < 20; i++) add_vec(8'($urandom()), 8'($urandom()), 1'($urandom()), "R6");

        // R6: carry from the segment below, codes 10 and 11.
        set_adder_masks(2'b10);
        load_cfg();
        add_vec(8'h80, 8'h7F, 1'b1, "R6 prev carry");
        for (int i = 0; i < 20; i++) add_vec(8'($urandom()), 8'($urandom()), 1'($urandom()), "R6");
        set_adder_masks(2'b11);
        load_cfg();
        for (int i = 0; i < 20; i++) add_vec(8'($urandom()), 8'($urandom()), 1'($urandom()), "R6");

        // R3/R4/R5: random tables in both modes.
        for (int e = 0; e < NE; e++) mask_m[e] = {$urandom(), $urandom()};
        csel_m = 2'($urandom());
        load_cfg();
        for (int i = 0; i < 40; i++) begin
            logic [47:0] ins;
            logic        ar;
            logic        cp;
            ins = rnd48();
            ar  = 1'($urandom());
            cp  = 1'($urandom());
            drive(ins, ar, cp, model(ins, ar, cp), ar ? "R4/R5" : "R3");
            #1 check1(cout_chain, model(ins, ar, cp) >> 8, "R8");
        end
        // R4: flipping input bit 5 in arithmetic mode changes nothing.
        for (int i = 0; i < 10; i++) begin
            logic [47:0] ins;
            logic [8:0]  ref9;
            ins  = rnd48();
            ref9 = model(ins, 1'b1, 1'b0);
            for (int e = 0; e < NE; e++) ins[e*6 + 5] = ~ins[e*6 + 5];
            drive(ins, 1'b1, 1'b0, ref9, "R4 bit5 ignored");
        end

        repeat (4) @(posedge clk);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #1500000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule